// File: doc/BRIEF.md
# Masked Bit Modify and Test Unit

This execution unit works on one byte of memory at a time under an immediate mask. A command carries an operation code, a byte address and a mask. The unit reads the addressed byte over a request/ready memory port and then does one of two things. For a modify operation it ORs the mask into the byte, or clears the masked bits, and writes the result back to the same address. For a test operation it checks whether the masked bits of the byte are all ones or all zeros, and it reports a branch decision without writing anything.

The surrounding processor supplies the operands and uses the branch result. Fetching instructions and computing branch targets are outside this unit. The unit takes a command only while it is idle. It raises `busy` while it works and pulses `done` for one cycle when the operation is complete. The branch and zero results are valid from the `done` cycle until the next command finishes.

Top module: `bitop_unit`

## Requirements
- R1: Opcode 2'b00 (set) writes back the read byte ORed with the mask. Bits outside the mask are unchanged.
- R2: Opcode 2'b01 (clear) writes back the read byte ANDed with the inverted mask.
- R3: Opcode 2'b10 (branch if all set) forms (NOT byte) AND mask. `branch_taken` and `zero_flag` are both 1 exactly when that value is zero.
- R4: Opcode 2'b11 (branch if all clear) forms byte AND mask. `branch_taken` and `zero_flag` are both 1 exactly when that value is zero.
- R5: A test opcode (bit 1 set) makes exactly one read handshake and no write handshake.
- R6: A modify opcode (bit 1 clear) makes exactly one read handshake, then one write handshake to the same address as the read. After a modify, `branch_taken` is 0 and `zero_flag` is 1 exactly when the written byte is zero.
- R7: While `mem_req` is high and `mem_ready` is low, the unit holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady.
- R8: `done` is a single-cycle pulse. It comes only after the write handshake for a modify opcode, or after the read handshake for a test opcode.
- R9: `busy` goes high in the cycle after a command is accepted and stays high through the `done` cycle. `cmd_valid` is ignored while `busy` is high.
- R10: A zero mask makes set and clear write back the unchanged byte, and makes both test opcodes report branch taken.
- R11: After a synchronous active-low reset, `busy`, `done`, `mem_req`, `branch_taken` and `zero_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present; taken only when idle |
| cmd_op | input | 2 | Operation: 00 set, 01 clear, 10 branch if all set, 11 branch if all clear |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_mask | input | DATA_W | Immediate mask |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| branch_taken | output | 1 | Branch decision of the last test command |
| zero_flag | output | 1 | The last masked result was zero |
| mem_req | output | 1 | Memory request; held until `mem_ready` |
| mem_we | output | 1 | The request is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory accepts the request; read data is valid in this cycle |
| mem_rdata | input | DATA_W | Read data |

## Verification
The bench builds the unit with DATA_W=4 and ADDR_W=3. That size allows every opcode to be run against every pair of byte value and mask, 1024 commands in all, with the zero mask and the all-ones mask among them. Memory latency is changed from command to command between zero and two wait cycles. On about half of the commands the bench keeps driving a different, conflicting command while the unit is busy. Each modify command must write back exactly the predicted byte to the address it read from, and each test command must leave memory untouched.

// File: rtl/bitop_pkg.sv
// Package: shared opcode encoding for the masked bit modify/test unit.
// Assumes a 2-bit opcode where bit 1 distinguishes test (1) from modify (0).
package bitop_pkg;

    typedef enum logic [1:0] {
        OP_SET   = 2'b00,
        OP_CLEAR = 2'b01,
        OP_TALL1 = 2'b10,
        OP_TALL0 = 2'b11
    } bitop_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_WRITE = 2'b10,
        ST_FIN   = 2'b11
    } bitop_state_e;

    // True when the opcode only tests and never writes memory.
    function automatic logic op_is_test(input bitop_op_e op);
        return op[1];
    endfunction

endpackage

// File: rtl/bitop_mask_alu.sv
// Module: bitop_mask_alu
// Purely combinational mask logic. Given the opcode, the byte read from memory
// and the mask, it produces the byte to write back and a zero indication.
// For modify opcodes the zero indication is taken from the new byte. For test
// opcodes it is taken from the masked test word.
// Assumes nothing about timing; the caller registers the outputs.
module bitop_mask_alu
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  bitop_op_e            op,
    input  logic [DATA_W-1:0]    din,
    input  logic [DATA_W-1:0]    mask,
    output logic [DATA_W-1:0]    new_byte,
    output logic                 is_zero
);

    logic [DATA_W-1:0] test_word;
    logic [DATA_W-1:0] check_word;

    // Per-bit modify and test terms; each bit is independent of its neighbours.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        always_comb begin : p_bit
            new_byte[i]  = (op == OP_SET) ? (din[i] | mask[i]) : (din[i] & ~mask[i]);
            test_word[i] = (op == OP_TALL1) ? (~din[i] & mask[i]) : (din[i] & mask[i]);
        end
    end

    // Select the word whose zero state is reported.
    always_comb begin : p_zero
        check_word = op_is_test(op) ? test_word : new_byte;
        is_zero    = (check_word == '0);
    end

endmodule

// File: rtl/bitop_ctrl.sv
// Module: bitop_ctrl
// Sequencer for one command: idle -> read -> (write) -> finish -> idle.
// Assumes a request/ready memory port where a transfer completes on a clock
// edge at which both mem_req and mem_ready are high. Read data is valid with
// mem_ready. Reset is synchronous and active low.
module bitop_ctrl
    import bitop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_is_test,
    input  logic held_is_test,
    input  logic mem_ready,
    output logic accept,
    output logic rd_fire,
    output logic busy,
    output logic done,
    output logic mem_req,
    output logic mem_we
);

    bitop_state_e st_q, st_d;

    // Decode handshake events from the current state.
    always_comb begin : p_events
        accept  = (st_q == ST_IDLE) && cmd_valid;
        rd_fire = (st_q == ST_READ) && mem_ready;
    end

    // Next-state selection.
    always_comb begin : p_next
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (cmd_valid) st_d = ST_READ;
            ST_READ:  if (mem_ready) st_d = held_is_test ? ST_FIN : ST_WRITE;
            ST_WRITE: if (mem_ready) st_d = ST_FIN;
            ST_FIN:   st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin : p_state
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Moore outputs decoded from the state.
    always_comb begin : p_outs
        busy    = (st_q != ST_IDLE);
        done    = (st_q == ST_FIN);
        mem_req = (st_q == ST_READ) || (st_q == ST_WRITE);
        mem_we  = (st_q == ST_WRITE);
    end

    logic unused_cmd_test;
    assign unused_cmd_test = cmd_is_test;

endmodule

// File: rtl/bitop_unit.sv
// Module: bitop_unit (top)
// Masked bit set/clear/test execution unit. It latches the command when idle,
// reads the byte, applies the mask and either writes the result back or
// reports a branch decision. Results are held from done until the next
// command completes. Assumes the memory port rules described in bitop_ctrl.
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_mask,
    output logic              busy,
    output logic              done,
    output logic              branch_taken,
    output logic              zero_flag,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);

    bitop_op_e         op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] wdata_q;
    logic              accept, rd_fire;
    logic [DATA_W-1:0] alu_byte;
    logic              alu_zero;

    bitop_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_is_test  (cmd_op[1]),
        .held_is_test (op_is_test(op_q)),
        .mem_ready    (mem_ready),
        .accept       (accept),
        .rd_fire      (rd_fire),
        .busy         (busy),
        .done         (done),
        .mem_req      (mem_req),
        .mem_we       (mem_we)
    );

    bitop_mask_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (op_q),
        .din      (mem_rdata),
        .mask     (mask_q),
        .new_byte (alu_byte),
        .is_zero  (alu_zero)
    );

    // Capture the command operands on acceptance.
    always_ff @(posedge clk) begin : p_cmd
        if (!rst_n) begin
            op_q   <= OP_SET;
            addr_q <= '0;
            mask_q <= '0;
        end else if (accept) begin
            op_q   <= bitop_op_e'(cmd_op);
            addr_q <= cmd_addr;
            mask_q <= cmd_mask;
        end
    end

    // Capture the mask result and the flags when the read data arrives.
    always_ff @(posedge clk) begin : p_result
        if (!rst_n) begin
            wdata_q      <= '0;
            branch_taken <= 1'b0;
            zero_flag    <= 1'b0;
        end else if (rd_fire) begin
            wdata_q      <= alu_byte;
            branch_taken <= op_is_test(op_q) && alu_zero;
            zero_flag    <= alu_zero;
        end
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;

endmodule

// File: rtl/bitop_unit_chk.sv
// Module: bitop_unit_chk
// Protocol and mask checker, attached to every bitop_unit instance by bind.
// It reads the top's ports and the latched opcode and mask.
module bitop_unit_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [1:0]        op_q,
    input logic [DATA_W-1:0] mask_q
);

    // R7: request and payload held until the memory accepts them
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R5: a test opcode never drives a write
    p_test_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !op_q[1]);

    // R1: set write data has every masked bit high
    p_set_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && op_q == 2'b00 |-> (mem_wdata & mask_q) == mask_q);

    // R2: clear write data has every masked bit low
    p_clear_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && op_q == 2'b01 |-> (mem_wdata & mask_q) == '0);

    // R8: done lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done follows a completed transfer
    p_done_after_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_req && mem_ready));

    // R9: busy covers done, and work starts only from an offered command
    p_busy_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .op_q      (op_q),
    .mask_q    (mask_q)
);

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;

    localparam int DW = 4;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_mask = '0;
    logic          busy, done, branch_taken, zero_flag, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ready = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    logic [DW-1:0] mem [1<<AW];
    int            lat_sel = 0;
    int            wcnt = 0;
    int            rd_cnt = 0, wr_cnt = 0;
    logic [AW-1:0] last_ra, last_wa;
    logic [DW-1:0] last_wd;
    int            n_tests = 0, n_fail = 0;
    int            cyc = 0;

    always #2 clk = ~clk;

    bitop_unit #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_mask(cmd_mask), .busy(busy), .done(done),
        .branch_taken(branch_taken), .zero_flag(zero_flag), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    // Memory model with a variable wait count, driven on the falling edge
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt >= lat_sel) begin
                mem_ready = 1'b1;
                mem_rdata = mem[mem_addr];
            end else begin
                wcnt++;
            end
        end
    end

    // Count handshakes and record their addresses and data
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_ready && !mem_we) begin
            rd_cnt <= rd_cnt + 1;
            last_ra <= mem_addr;
        end
        if (mem_req && mem_ready && mem_we) begin
            wr_cnt <= wr_cnt + 1;
            last_wa <= mem_addr;
            last_wd <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_cmd(input int op, input int b, input int m, input int a,
                           input int lat, input bit noise);
        int rc0, wc0, n;
        logic [DW-1:0] bv, mv, exp_w;
        bit exp_br, exp_z;
        bv = DW'(b);
        mv = DW'(m);
        @(negedge clk);
        mem[a] = bv;
        lat_sel = lat;
        rc0 = rd_cnt;
        wc0 = wr_cnt;
        cmd_valid = 1'b1;
        cmd_op = 2'(op);
        cmd_addr = AW'(a);
        cmd_mask = mv;
        @(negedge clk);
        chk(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
        if (noise) begin
            cmd_op = 2'(op ^ 1);
            cmd_mask = ~mv;
            cmd_addr = AW'(a + 1);
        end else begin
            cmd_valid = 1'b0;
        end
        n = 0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        cmd_valid = 1'b0;
        chk(done == 1'b1, "R8 done seen", int'(done), 1);
        case (op)
            0: exp_w = bv | mv;
            1: exp_w = bv & ~mv;
            default: exp_w = bv;
        endcase
        if (op >= 2) begin
            exp_z = (op == 2) ? (((~bv) & mv) == '0) : ((bv & mv) == '0);
            exp_br = exp_z;
            chk(branch_taken == exp_br, op == 2 ? "R3 branch" : "R4 branch", int'(branch_taken), int'(exp_br));
            chk(zero_flag == exp_z, op == 2 ? "R3 zero" : "R4 zero", int'(zero_flag), int'(exp_z));
            chk(wr_cnt == wc0, "R5 no write", wr_cnt - wc0, 0);
            chk(rd_cnt == rc0 + 1, "R5 one read", rd_cnt - rc0, 1);
            if (m == 0) chk(branch_taken == 1'b1, "R10 zero mask taken", int'(branch_taken), 1);
        end else begin
            chk(rd_cnt == rc0 + 1 && wr_cnt == wc0 + 1, "R6 one read one write",
                (rd_cnt - rc0) * 10 + (wr_cnt - wc0), 11);
            chk(last_wa == AW'(a) && last_ra == AW'(a), "R6 same address", int'(last_wa), a);
            chk(last_wd == exp_w, op == 0 ? "R1 set data" : "R2 clear data", int'(last_wd), int'(exp_w));
            chk(branch_taken == 1'b0 && zero_flag == (exp_w == '0), "R6 modify flags",
                int'({branch_taken, zero_flag}), int'({1'b0, exp_w == '0}));
            if (m == 0) chk(last_wd == bv, "R10 zero mask unchanged", int'(last_wd), b);
        end
        @(negedge clk);
        chk(!done && !busy, "R8 R9 single pulse and idle", int'({done, busy}), 0);
        chk(!mem_req, "R9 conflicting command ignored", int'(mem_req), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req && !branch_taken && !zero_flag, "R11 reset state",
            int'({busy, done, mem_req, branch_taken, zero_flag}), 0);
        rst_n = 1'b1;
        for (int op = 0; op < 4; op++)
            for (int b = 0; b < (1 << DW); b++)
                for (int m = 0; m < (1 << DW); m++)
                    run_cmd(op, b, m, (b + m) % (1 << AW), (b ^ m) % 3, ((m ^ (b >> 1)) & 1) == 1);
        // R7 is covered by the checker across all of these latencies
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        wait (cyc > 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule